// File: doc/BRIEF.md
# Serial PLL Bit-Stream Loader

This block sits between a host register port and the parallel programming input of a clock synthesizer. The host programs the synthesizer one bit at a time. Each write to the block's register carries one data bit in bit 0. A flag in bit 1 marks the last write of a frame. The block collects the bits in a shift register and counts them. When a frame of exactly 56 bits closes with the flag, it presents the whole word on a parallel output and raises a one-cycle load strobe for the synthesizer.

A frame is seven bytes, and each byte is sent most significant bit first. The first bit sent therefore ends up in the top bit of the output word. A frame can be malformed in two ways: it ends early, or it reaches its 56th bit without the flag. In either case the block drops the partial word, raises a one-cycle error strobe and waits for a fresh frame. The last good word stays on the output.

Top module: `pll_stream_loader`

## Requirements
- R1: While reset is low at a clock edge, the next outputs are an all-zero word, no load strobe and no error strobe. The bit count restarts at zero.
- R2: Each cycle with `wr_en` high takes in exactly one bit, the value of `wr_data[0]`. The bits of `wr_data` above bit 1 have no effect on any output.
- R3: Bit order in the loaded word: the first bit taken in lands in bit 55 and the last in bit 0. Byte k of the frame (k = 0 to 6, each sent MSB first) occupies bits 55-8k down to 48-8k.
- R4: A write that carries the hold flag (`wr_data[1]` = 1) and is the 56th bit of the frame updates `pll_word` and raises `load_pulse` for exactly one cycle. Both become visible in the cycle after that write's clock edge.
- R5: `pll_word` changes only in a cycle where `load_pulse` is high. Between loads it holds its value.
- R6: A write with the hold flag set before 55 bits have been taken in raises `err_pulse` for one cycle with no load. `pll_word` is unchanged and the partial bits are discarded, so the next 56-write frame loads correctly.
- R7: A 56th write without the hold flag raises `err_pulse` for one cycle, discards the frame and leaves `pll_word` unchanged.
- R8: The bit count returns to zero after every completed load and after every error, so frames can be loaded back to back.
- R9: Cycles with `wr_en` low, any number of them and at any point in a frame, change nothing and raise no strobe.
- R10: `load_pulse` and `err_pulse` are never high together, and neither is high in a cycle that does not follow a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Host write strobe for the clock register |
| wr_data | input | DATA_W (32) | Write data: bit 0 is the stream bit, bit 1 is the hold flag, other bits ignored |
| pll_word | output | FRAME_BITS (56) | Last completed programming word |
| load_pulse | output | 1 | One-cycle strobe: `pll_word` has just been updated |
| err_pulse | output | 1 | One-cycle strobe: a malformed frame was discarded |

## Verification
A bit count that is off by one shows at the ports on the first frame after the fault. A well-formed frame then produces `err_pulse` instead of `load_pulse` one cycle after its final write, or a flagless 56th write slips through. A shift register that loses, swaps or misorders bits shows as a wrong `pll_word` in the same cycle as the load strobe. A partial word that survives an abort corrupts the word of the next good frame. The bench compares all three outputs against its model on every cycle, so each such fault is reported in the cycle where it first reaches a port.

// File: rtl/pll_loader_pkg.sv
// Package: shared types for the serial PLL loader.
// Assumes nothing beyond a standard elaborator.
package pll_loader_pkg;

    // What a single host write does to the frame being assembled.
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,   // no write this cycle
        ACT_SHIFT = 2'd1,   // take a bit, frame still open
        ACT_LOAD  = 2'd2,   // final bit with hold flag: publish word
        ACT_ABORT = 2'd3    // malformed frame: discard
    } wr_action_t;

endpackage

// File: rtl/pll_bit_counter.sv
// Module: pll_bit_counter
// Counts stream bits taken into the current frame and flags the
// position of the final bit. Assumes inc and clr are never both high.
module pll_bit_counter #(
    parameter int FRAME_BITS = 56,
    localparam int CNT_W = $clog2(FRAME_BITS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic clr,
    output logic at_last
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

    logic [CNT_W-1:0] cnt;

    // Purpose: advance on each shifted bit, restart on reset, load or abort.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Purpose: flag that the next bit taken in would be the last of the frame.
    always_comb begin
        at_last = (cnt == LAST_IDX);
    end

endmodule

// File: rtl/pll_frame_decode.sv
// Module: pll_frame_decode
// Classifies the current cycle from the write strobe, the hold flag and
// the counter position. Purely combinational.
module pll_frame_decode
    import pll_loader_pkg::*;
(
    input  logic       wr_en,
    input  logic       hold,
    input  logic       at_last,
    output wr_action_t action
);
    // Purpose: decide shift, load or abort for this cycle.
    always_comb begin
        if (!wr_en) begin
            action = ACT_IDLE;
        end else if (hold && at_last) begin
            action = ACT_LOAD;
        end else if (hold || at_last) begin
            action = ACT_ABORT;     // early hold, or final bit missing hold
        end else begin
            action = ACT_SHIFT;
        end
    end

endmodule

// File: rtl/pll_shift_reg.sv
// Module: pll_shift_reg
// Shift register that takes serial bits in at bit 0 and moves older
// bits upward. Exposes the value it would hold after the shift, so the
// final bit can be published in the same cycle it arrives.
module pll_shift_reg #(
    parameter int WIDTH = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift,
    input  logic             clr,
    input  logic             din,
    output logic [WIDTH-1:0] next_val
);
    logic [WIDTH-1:0] q;

    // Purpose: build the shifted value one cell at a time.
    assign next_val[0] = din;
    generate
        for (genvar i = 1; i < WIDTH; i++) begin : g_cell
            assign next_val[i] = q[i-1];
        end
    endgenerate

    // Purpose: hold partial frame; cleared on reset and when a frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (shift) begin
            q <= next_val;
        end
    end

endmodule

// File: rtl/pll_out_stage.sv
// Module: pll_out_stage
// Output register for the programming word plus the load and error
// strobes. Assumes action comes from pll_frame_decode.
module pll_out_stage
    import pll_loader_pkg::*;
#(
    parameter int WIDTH = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_action_t       action,
    input  logic [WIDTH-1:0] next_val,
    output logic [WIDTH-1:0] word,
    output logic             load_pulse,
    output logic             err_pulse
);
    // Purpose: latch a completed word and hold it until the next load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (action == ACT_LOAD) begin
            word <= next_val;
        end
    end

    // Purpose: one-cycle strobes for a completed or discarded frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_pulse <= 1'b0;
            err_pulse  <= 1'b0;
        end else begin
            load_pulse <= (action == ACT_LOAD);
            err_pulse  <= (action == ACT_ABORT);
        end
    end

endmodule

// File: rtl/pll_stream_loader.sv
// Module: pll_stream_loader (top)
// Collects a serial synthesizer programming stream, one bit per host
// write, and publishes the full word with a one-cycle load strobe.
// Assumes the host keeps wr_data valid while wr_en is high.
module pll_stream_loader
    import pll_loader_pkg::*;
#(
    parameter int FRAME_BYTES = 7,
    parameter int BYTE_BITS   = 8,
    parameter int DATA_W      = 32,
    parameter int BIT_POS     = 0,
    parameter int HOLD_POS    = 1,
    localparam int FRAME_BITS = FRAME_BYTES * BYTE_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [FRAME_BITS-1:0] pll_word,
    output logic                  load_pulse,
    output logic                  err_pulse
);
    wr_action_t            action;
    logic                  at_last;
    logic [FRAME_BITS-1:0] next_val;
    logic                  frame_end;

    // Purpose: any load or abort closes the current frame.
    assign frame_end = (action == ACT_LOAD) || (action == ACT_ABORT);

    pll_frame_decode u_decode (
        .wr_en   (wr_en),
        .hold    (wr_data[HOLD_POS]),
        .at_last (at_last),
        .action  (action)
    );

    pll_bit_counter #(.FRAME_BITS(FRAME_BITS)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (action == ACT_SHIFT),
        .clr     (frame_end),
        .at_last (at_last)
    );

    pll_shift_reg #(.WIDTH(FRAME_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift    (action == ACT_SHIFT),
        .clr      (frame_end),
        .din      (wr_data[BIT_POS]),
        .next_val (next_val)
    );

    pll_out_stage #(.WIDTH(FRAME_BITS)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .action     (action),
        .next_val   (next_val),
        .word       (pll_word),
        .load_pulse (load_pulse),
        .err_pulse  (err_pulse)
    );

endmodule

// File: rtl/pll_stream_loader_chk.sv
// Module: pll_stream_loader_chk
// Port-level temporal checks, bound into every pll_stream_loader.
module pll_stream_loader_chk #(
    parameter int DATA_W     = 32,
    parameter int HOLD_POS   = 1,
    parameter int FRAME_BITS = 56
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [DATA_W-1:0]     wr_data,
    input logic [FRAME_BITS-1:0] pll_word,
    input logic                  load_pulse,
    input logic                  err_pulse
);
    // R10: strobes are exclusive
    assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_pulse && err_pulse));

    // R10: no strobe without a write in the previous cycle
    assert_strobe_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!load_pulse && !err_pulse));

    // R4: a load strobe follows a write carrying the hold flag, and lasts one cycle
    assert_load_after_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[HOLD_POS]) |=> !load_pulse);

    assert_load_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> !load_pulse);

    // R5: word changes only together with the load strobe
    assert_word_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pulse |=> (load_pulse || $stable(pll_word)));

endmodule

bind pll_stream_loader pll_stream_loader_chk #(
    .DATA_W     (DATA_W),
    .HOLD_POS   (HOLD_POS),
    .FRAME_BITS (FRAME_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .pll_word   (pll_word),
    .load_pulse (load_pulse),
    .err_pulse  (err_pulse)
);

// File: tb/tb_pll_stream_loader.sv
// Bench for pll_stream_loader: behavioural queue model compared every cycle.
module tb_pll_stream_loader;
    localparam int DATA_W = 32;
    localparam int NB     = 56;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [NB-1:0]     pll_word;
    logic              load_pulse;
    logic              err_pulse;

    always #2 clk = ~clk;   // 250 MHz

    pll_stream_loader dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .pll_word(pll_word), .load_pulse(load_pulse), .err_pulse(err_pulse)
    );

    int n_checks = 0;
    int n_fails  = 0;
    string cur_req = "R1";
    bit compare_on = 1'b0;

    // Reference model state
    bit          mq[$];
    logic [NB-1:0] m_word = '0;
    bit          m_load = 0;
    bit          m_err  = 0;

    // Model: update on every rising edge from requirement text.
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_word = '0; m_load = 0; m_err = 0;
        end else begin
            m_load = 0; m_err = 0;
            if (wr_en) begin
                mq.push_back(wr_data[0]);
                if (wr_data[1] && mq.size() == NB) begin
                    for (int i = 0; i < NB; i++) m_word[NB-1-i] = mq[i];
                    m_load = 1;
                    mq.delete();
                end else if (wr_data[1] || mq.size() == NB) begin
                    m_err = 1;
                    mq.delete();
                end
            end
        end
        compare_on = 1'b1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [NB-1:0] act, input logic [NB-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Every-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (compare_on) begin
            check(pll_word === m_word, cur_req, "pll_word", pll_word, m_word);
            check(load_pulse === m_load, cur_req, "load_pulse", NB'(load_pulse), NB'(m_load));
            check(err_pulse === m_err, cur_req, "err_pulse", NB'(err_pulse), NB'(m_err));
        end
    end

    // One host write; returns after the following falling edge.
    task automatic wr(input bit b, input bit hold, input logic [29:0] junk);
        wr_en   = 1'b1;
        wr_data = {junk, hold, b};
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send a whole frame of 7 bytes MSB first; gap inserts idle cycles.
    task automatic send_frame(input logic [NB-1:0] w, input int gap, input bit junk_on);
        for (int i = NB - 1; i >= 0; i--) begin
            wr(w[i], i == 0, junk_on ? 30'($urandom) : 30'd0);
            if (gap > 0 && (i % 5) == 0) idle(gap);
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    logic [NB-1:0] wa, wb, wc;
    initial begin
        wa = {8'hA5, 8'h3C, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h5A};
        wb = {8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hDE};
        wc = {8'hC3, 8'h7E, 8'h81, 8'h24, 8'h42, 8'h99, 8'h66};

        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        check(pll_word === '0 && !load_pulse && !err_pulse, "R1", "reset outputs",
              pll_word, '0);
        rst_n = 1'b1;
        idle(2);

        // R3 R4: plain frame, byte order MSB first
        cur_req = "R4";
        for (int i = NB - 1; i >= 1; i--) wr(wa[i], 1'b0, 30'd0);
        wr_en = 1'b1; wr_data = {30'd0, 1'b1, wa[0]};
        @(posedge clk); #1;
        check(load_pulse === 1'b1, "R4", "load strobe after final write", NB'(load_pulse), NB'(1));
        check(pll_word === wa, "R3", "bit/byte order", pll_word, wa);
        check(pll_word[55:48] === 8'hA5, "R3", "byte 0 on top", NB'(pll_word[55:48]), NB'(8'hA5));
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
        @(negedge clk);
        check(load_pulse === 1'b0, "R4", "strobe lasts one cycle", NB'(load_pulse), NB'(0));

        // R2 R9 R8: junk upper bits, idle gaps, back-to-back frames
        cur_req = "R2";
        send_frame(wb, 3, 1'b1);
        idle(1);
        check(pll_word === wb, "R2", "junk bits ignored", pll_word, wb);
        cur_req = "R8";
        send_frame(wc, 0, 1'b0);
        idle(1);
        check(pll_word === wc, "R8", "back-to-back load", pll_word, wc);
        cur_req = "R9";
        idle(20);
        check(pll_word === wc && !load_pulse && !err_pulse, "R9", "idle no effect", pll_word, wc);

        // R6: early hold after 20 bits, then full frame
        cur_req = "R6";
        for (int i = 0; i < 20; i++) wr(1'b1, 1'b0, 30'd0);
        wr_en = 1'b1; wr_data = 32'h3;
        @(posedge clk); #1;
        check(err_pulse === 1'b1 && load_pulse === 1'b0, "R6", "early hold error",
              NB'({load_pulse, err_pulse}), NB'(2'b01));
        check(pll_word === wc, "R6", "word kept on error", pll_word, wc);
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
        // hold on the very first bit
        wr(1'b0, 1'b1, 30'd0);
        send_frame(wa, 1, 1'b0);
        idle(1);
        check(pll_word === wa, "R6", "partial discarded", pll_word, wa);

        // R7: 56 writes without hold
        cur_req = "R7";
        for (int i = 0; i < NB - 1; i++) wr(1'b1, 1'b0, 30'd0);
        wr_en = 1'b1; wr_data = 32'h1;
        @(posedge clk); #1;
        check(err_pulse === 1'b1 && load_pulse === 1'b0, "R7", "missing hold error",
              NB'({load_pulse, err_pulse}), NB'(2'b01));
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
        check(pll_word === wa, "R7", "word kept", pll_word, wa);
        send_frame(wb, 0, 1'b1);
        idle(1);
        check(pll_word === wb, "R7", "recovery frame", pll_word, wb);

        // R5 R10: covered every cycle by the model comparison
        cur_req = "R10";
        idle(4);
        check(!(load_pulse && err_pulse), "R10", "strobes exclusive", NB'({load_pulse, err_pulse}), '0);
        cur_req = "R5";
        idle(2);
        check(pll_word === wb, "R5", "word held", pll_word, wb);

        // R1: reset mid-frame clears word and count
        cur_req = "R1";
        for (int i = 0; i < 10; i++) wr(1'b1, 1'b0, 30'd0);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        check(pll_word === '0, "R1", "reset clears word", pll_word, '0);
        send_frame(wc, 0, 1'b0);
        idle(1);
        check(pll_word === wc, "R1", "count cleared by reset", pll_word, wc);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule